// File: doc/BRIEF.md
# Count/Compare Tick Timer with Routed Interrupt

This block is a processor-side tick timer. A free-running counter advances by one on every cycle of its timebase. The block is meant for a 100 MHz clock, so one tick lasts 10 ns. Software loads a match value into a compare register. When the counter steps onto that value, a sticky pending flag is set and one of eight interrupt lines is driven high. The line is picked at run time by a 3-bit routing field.

Software reaches the timer through a single write port with a 2-bit register select and reads the counter continuously on a dedicated output. A freeze bit in the control register stops the counter. While it is set, no match can occur. The only way to clear a pending interrupt is to write the compare register. A build-time switch decides whether the pending flag is also exported as a status bit, or whether only the interrupt line is driven.

Top module: `tick_compare_timer`

## Requirements
- R1: While the freeze bit is clear and no counter write happens, `count_o` rises by exactly 1 on each clock edge. The step from 0xFFFFFFFF to 0 is silent and sets no pending flag.
- R2: While the freeze bit (control bit 0) is set, `count_o` holds its value and no match is raised.
- R3: When an increment makes the counter equal to the compare value, the pending flag is set on that same clock edge, and line `irq_o[route]` goes high.
- R4: A write with `wr_sel`=1 loads the compare register and clears the pending flag, which drops the line. This write wins over a match on the same edge.
- R5: The routing field is control bits 3:1. `irq_o` has at most one bit high, at the index given by that field. A change of the field moves an active request to the new line at once.
- R6: A write with `wr_sel`=0 loads the counter on the next edge, whether the freeze bit is set or clear, and takes priority over the increment. Loading a value equal to the compare value raises no match.
- R7: Once set, the pending flag stays set until the next compare write, even while the counter moves past the compare value.
- R8: A synchronous active-low reset clears the counter, the compare value, the pending flag and the freeze bit, and sets the routing field to 0.
- R9: With `PEND_FLAG_EN`=0, `pend_flag_o` stays 0 while `irq_o` behaves exactly as with the flag enabled. With `PEND_FLAG_EN`=1, `pend_flag_o` reports the pending flag.
- R10: A write with `wr_sel`=3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock, one count per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Select: 0 counter, 1 compare, 2 control, 3 unused |
| wr_data | input | 32 | Write data |
| count_o | output | 32 | Current counter value |
| irq_o | output | 8 | Interrupt lines, at most one high |
| pend_flag_o | output | 1 | Pending status bit (0 when disabled at build time) |

## Verification
The match path is exercised in five situations. A plain count-up onto a compare value shows that the flag rises on the correct edge. A run across the 32-bit wrap shows that the wrap itself is silent. A freeze placed one tick before the match shows that a frozen counter raises nothing. A counter load straight onto the compare value shows that only increments can match. A compare rewrite on the matching edge shows that the clear takes priority. Route changes made while a request is pending show whether the line moves instantly. A second instance with the status flag disabled, driven in lockstep, must produce the same interrupt lines while its status bit stays low.

// File: rtl/ctm_pkg.sv
// Package: shared register-select encoding and control field positions
// for the tick/compare timer. Assumes a 2-bit select on the write port.
package ctm_pkg;
    typedef enum logic [1:0] {
        SEL_COUNT   = 2'd0,
        SEL_COMPARE = 2'd1,
        SEL_CTRL    = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    localparam int FREEZE_BIT = 0;
    localparam int ROUTE_LSB  = 1;
endpackage

// File: rtl/ctm_counter.sv
// Module: the free-running counter. It loads on a write and otherwise
// adds one per cycle unless frozen. It assumes that the load takes
// priority over the increment. It exports the incremented value and an
// advance flag so that the match logic can see a step before it lands.
module ctm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             freeze,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_inc,
    output logic             adv
);
    // Purpose: next value and whether this edge is an increment.
    always_comb begin
        cnt_inc = cnt_q + CNT_W'(1);
        adv     = !load && !freeze;
    end

    // Purpose: counter register with load priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (adv)
            cnt_q <= cnt_inc;
    end
endmodule

// File: rtl/ctm_pending.sv
// Module: holds the compare value and the sticky pending flag. It
// assumes that a match counts only when an increment lands on the compare
// value. A compare write clears the flag and wins over a match on the
// same edge.
module ctm_pending #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             adv,
    input  logic [CNT_W-1:0] cnt_inc,
    output logic [CNT_W-1:0] cmp_q,
    output logic             pend_q
);
    logic hit;

    // Purpose: detect an increment that lands on the compare value.
    always_comb hit = adv && (cnt_inc == cmp_q);

    // Purpose: compare register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (cmp_wr)
            cmp_q <= cmp_wdata;
    end

    // Purpose: sticky pending flag, cleared only by a compare write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (cmp_wr)
            pend_q <= 1'b0;
        else if (hit)
            pend_q <= 1'b1;
    end
endmodule

// File: rtl/ctm_router.sv
// Module: steers the pending request onto one of 2**ROUTE_W lines. It
// is purely combinational, so a route change moves the request at once.
module ctm_router #(
    parameter int ROUTE_W = 3,
    localparam int LINES  = 1 << ROUTE_W
) (
    input  logic               pend,
    input  logic [ROUTE_W-1:0] route,
    output logic [LINES-1:0]   irq
);
    // Purpose: one decoder slice per interrupt line.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign irq[i] = pend && (route == ROUTE_W'(i));
    end
endmodule

// File: rtl/tick_compare_timer.sv
// Module: top of the tick/compare timer. It decodes the write port,
// holds the control register (freeze bit, routing field) and ties the
// counter, match and router together. It assumes one register write
// per cycle and a synchronous active-low reset.
module tick_compare_timer #(
    parameter int CNT_W        = 32,
    parameter int ROUTE_W      = 3,
    parameter bit PEND_FLAG_EN = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_sel,
    input  logic [CNT_W-1:0]          wr_data,
    output logic [CNT_W-1:0]          count_o,
    output logic [(1<<ROUTE_W)-1:0]   irq_o,
    output logic                      pend_flag_o
);
    import ctm_pkg::*;

    logic               cnt_wr, cmp_wr, ctl_wr;
    logic               freeze_q;
    logic [ROUTE_W-1:0] route_q;
    logic [CNT_W-1:0]   cnt_q, cnt_inc, cmp_q;
    logic               adv, pend_q;

    // Purpose: decode the register select into per-register strobes.
    always_comb begin
        cnt_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_COUNT);
        cmp_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_COMPARE);
        ctl_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
    end

    // Purpose: control register holding the freeze bit and routing field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freeze_q <= 1'b0;
            route_q  <= '0;
        end else if (ctl_wr) begin
            freeze_q <= wr_data[FREEZE_BIT];
            route_q  <= wr_data[ROUTE_LSB +: ROUTE_W];
        end
    end

    ctm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_wr),
        .load_val (wr_data),
        .freeze   (freeze_q),
        .cnt_q    (cnt_q),
        .cnt_inc  (cnt_inc),
        .adv      (adv)
    );

    ctm_pending #(.CNT_W(CNT_W)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (wr_data),
        .adv       (adv),
        .cnt_inc   (cnt_inc),
        .cmp_q     (cmp_q),
        .pend_q    (pend_q)
    );

    ctm_router #(.ROUTE_W(ROUTE_W)) u_route (
        .pend  (pend_q),
        .route (route_q),
        .irq   (irq_o)
    );

    assign count_o = cnt_q;

    // Purpose: pick whether the pending flag is exported as status.
    if (PEND_FLAG_EN) begin : g_flag
        assign pend_flag_o = pend_q;
    end else begin : g_noflag
        assign pend_flag_o = 1'b0;
    end
endmodule

// File: rtl/tick_compare_timer_chk.sv
// Module: property checker for the tick/compare timer, bound to the top.
// It assumes the select encoding of ctm_pkg.
module tick_compare_timer_chk #(
    parameter int CNT_W   = 32,
    parameter int ROUTE_W = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [1:0]              wr_sel,
    input logic [CNT_W-1:0]        wr_data,
    input logic [CNT_W-1:0]        count_o,
    input logic [(1<<ROUTE_W)-1:0] irq_o,
    input logic                    freeze,
    input logic                    pend
);
    logic cnt_w, cmp_w;
    assign cnt_w = wr_en && (wr_sel == 2'd0);
    assign cmp_w = wr_en && (wr_sel == 2'd1);

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!freeze && !cnt_w) |=> (count_o == $past(count_o) + CNT_W'(1))); // R1

    AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !cnt_w) |=> $stable(count_o)); // R2

    AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_w |=> (!pend && (irq_o == '0))); // R4

    AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_o)); // R5

    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_w |=> (count_o == $past(wr_data))); // R6

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !cmp_w) |=> pend); // R7

    AST_LINE_MATCHES_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (pend == (irq_o != '0))); // R5
endmodule

bind tick_compare_timer tick_compare_timer_chk #(
    .CNT_W   (CNT_W),
    .ROUTE_W (ROUTE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .count_o (count_o),
    .irq_o   (irq_o),
    .freeze  (freeze_q),
    .pend    (pend_q)
);

// File: tb/tb_tick_compare_timer.sv
// Scoreboard bench: the driver applies one cycle of stimulus and pushes
// the expected post-edge outputs; the monitor pops and compares them.
module tb_tick_compare_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] count_o, count_np;
    logic [7:0]  irq_o, irq_np;
    logic        pend_flag_o, pend_np;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        string       tag;
        logic [31:0] cnt;
        logic [7:0]  irq;
        logic        pend;
    } exp_t;
    exp_t sb[$];

    // reference state, built from the requirements
    logic [31:0] m_cnt = '0, m_cmp = '0;
    logic        m_frz = 1'b0, m_pend = 1'b0;
    logic [2:0]  m_route = '0;

    always #2.5 clk = ~clk;

    tick_compare_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .count_o(count_o), .irq_o(irq_o),
        .pend_flag_o(pend_flag_o)
    );

    tick_compare_timer #(.PEND_FLAG_EN(1'b0)) dut_np (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .count_o(count_np), .irq_o(irq_np),
        .pend_flag_o(pend_np)
    );

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one cycle of stimulus plus the expected outcome
    task automatic cyc(bit rst, bit we, logic [1:0] sel, logic [31:0] d, string tag);
        exp_t e;
        bit inc;
        @(negedge clk);
        rst_n = !rst; wr_en = we; wr_sel = sel; wr_data = d;
        if (rst) begin
            m_cnt = '0; m_cmp = '0; m_frz = 1'b0; m_pend = 1'b0; m_route = '0;
        end else begin
            inc = !(we && sel == 2'd0) && !m_frz;
            if (we && sel == 2'd1) m_pend = 1'b0;
            else if (inc && (m_cnt + 32'd1) == m_cmp) m_pend = 1'b1;
            if (we && sel == 2'd0) m_cnt = d;
            else if (inc) m_cnt = m_cnt + 32'd1;
            if (we && sel == 2'd1) m_cmp = d;
            if (we && sel == 2'd2) begin m_frz = d[0]; m_route = d[3:1]; end
        end
        e.tag = tag; e.cnt = m_cnt; e.pend = m_pend;
        e.irq = m_pend ? (8'd1 << m_route) : 8'd0;
        sb.push_back(e);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 32'd0, tag);
    endtask

    // monitor: compare just after each edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk); #1;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                chk(e.tag, "count", count_o, e.cnt);
                chk(e.tag, "irq", {24'd0, irq_o}, {24'd0, e.irq});
                chk(e.tag, "pend", {31'd0, pend_flag_o}, {31'd0, e.pend});
                chk("R9", "irq_noflag", {24'd0, irq_np}, {24'd0, e.irq});
                chk("R9", "pend_noflag", {31'd0, pend_np}, 32'd0);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        cyc(1'b1, 1'b0, 2'd0, 32'd0, "R8");
        cyc(1'b1, 1'b0, 2'd0, 32'd0, "R8");
        idle(5, "R1");
        // plain count-up onto a compare value
        cyc(1'b0, 1'b1, 2'd1, 32'd20, "R4");
        idle(20, "R3");
        idle(6, "R7");
        // route moves the request
        cyc(1'b0, 1'b1, 2'd2, {28'd0, 3'd5, 1'b0}, "R5");
        cyc(1'b0, 1'b1, 2'd2, {28'd0, 3'd7, 1'b0}, "R5");
        cyc(1'b0, 1'b1, 2'd3, 32'hFFFF_FFFF, "R10");
        idle(2, "R10");
        cyc(1'b0, 1'b1, 2'd1, 32'd100, "R4");
        // freeze one tick before the match, load while frozen
        cyc(1'b0, 1'b1, 2'd2, {28'd0, 3'd2, 1'b1}, "R2");
        cyc(1'b0, 1'b1, 2'd0, 32'd99, "R6");
        idle(10, "R2");
        cyc(1'b0, 1'b1, 2'd2, {28'd0, 3'd2, 1'b0}, "R3");
        idle(3, "R7");
        // load straight onto the compare value: no match
        cyc(1'b0, 1'b1, 2'd1, 32'd300, "R4");
        cyc(1'b0, 1'b1, 2'd0, 32'd300, "R6");
        idle(4, "R6");
        // wrap across 0xFFFFFFFF
        cyc(1'b0, 1'b1, 2'd1, 32'd3, "R4");
        cyc(1'b0, 1'b1, 2'd0, 32'hFFFF_FFFD, "R6");
        idle(8, "R1");
        // compare write on the matching edge wins
        cyc(1'b0, 1'b1, 2'd1, 32'd500, "R4");
        cyc(1'b0, 1'b1, 2'd0, 32'd498, "R6");
        cyc(1'b0, 1'b0, 2'd0, 32'd0, "R1");
        cyc(1'b0, 1'b1, 2'd1, 32'd600, "R4");
        idle(3, "R4");
        // reset from a busy state
        cyc(1'b0, 1'b1, 2'd1, 32'd510, "R4");
        idle(8, "R3");
        cyc(1'b0, 1'b1, 2'd2, {28'd0, 3'd6, 1'b1}, "R5");
        cyc(1'b1, 1'b0, 2'd0, 32'd0, "R8");
        idle(4, "R8");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule